// File: doc/BRIEF.md
# Bus-Snooping Shadow Video Controller

This block sits beside a host processor and listens to its memory write bus. It never drives that bus and never stalls it. Any write that lands in the video pages, or in the per-row indirection table, is copied into the block's own storage. All other writes pass by untouched. From its private copy the block draws the picture on its own raster timing. It generates horizontal sync, vertical sync and a data-enable, so the host no longer has to produce video by software.

Each source row is shown on four consecutive output lines. The table has one two-byte entry per source row. The even byte names the page that holds the row, and the odd byte gives the start offset within that page. If entry 0 names page 0, it is not a real row: its offset byte carries a display mode code instead. That code takes effect only at the start of vertical blanking, so the last picture stays up until the switch.

The block decodes and latches the mode but renders only mode 0. Under any other code it shows black. Page and offset are the high and low bytes of the 16-bit host address. `ROWS` and `SB` must be powers of two.

Top module: `shadow_vidctl`

## Requirements
- R1: A host write with `hwe_i` high whose page is in `VBASE..VBASE+ROWS-1` and whose offset is below `SB` is stored, and it shows up in later frames wherever that byte is displayed.
- R2: A write is ignored and changes no displayed pixel or mode when `hwe_i` is low, or when it falls outside both the shadowed video bytes and table offsets `0..2*ROWS-1` of page `TBL_PAGE`.
- R3: With counters h (0..H_TOT-1) and v (0..V_TOT-1), `hs_o` is high for `H_ACT+H_FP <= h < H_ACT+H_FP+H_SYNC` and `vs_o` is high for `V_ACT+V_FP <= v < V_ACT+V_FP+V_SYNC`. Both are active high and set one cycle after the counter state, with no dependence on host activity.
- R4: `de_o` is high exactly for h < H_ACT and v < V_ACT, where V_ACT = 4*ROWS. It is set one cycle after the counter state.
- R5: Output line v shows source row v/4, so each source row appears on four consecutive lines.
- R6: In mode 0, pixel h of row r is the shadow byte of page P at offset (O+h) mod SB. P is the even table byte 2r and O is the odd byte 2r+1.
- R7: A row whose table page is outside the video pages shows pixel value 0. This includes page 0 in entries other than entry 0.
- R8: When table entry 0 has page byte 0, the pending mode is its offset byte. Otherwise the pending mode is 0.
- R9: `mode_o` takes the pending mode only at the clock edge that ends the last active line, so no frame mixes two modes.
- R10: While `mode_o` is not 0, `pix_o` is 0.
- R11: A video write on the same cycle as the display read of that byte shows the old byte on that cycle. Writes are accepted on every cycle, in any raster phase.
- R12: During and after a synchronous reset (`rst_n` low), all outputs are 0, the raster restarts at h=v=0, and every table entry reads page 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| haddr_i | input | 16 | Host write address, page in bits 15:8, offset in 7:0 |
| hdata_i | input | 8 | Host write data |
| hwe_i | input | 1 | Host write strobe |
| pix_o | output | 8 | Pixel value |
| de_o | output | 1 | Active display enable |
| hs_o | output | 1 | Horizontal sync, active high |
| vs_o | output | 1 | Vertical sync, active high |
| mode_o | output | 8 | Latched display mode code |

## Verification
The assertions assume a synchronous reset is applied before the first checked cycle. The host write strobe is treated as a plain one-cycle-per-write signal with address and data valid on the same edge. The bench drives all host inputs on the falling clock edge, one write per cycle at most, and holds reset low for several cycles at the start. It places mode writes mid-frame on purpose, and it mixes valid, out-of-range and strobe-low writes through active display, so the "no mode change except at vblank" property is tested under real traffic.

// File: rtl/shadow_vidctl.sv
module shadow_vidctl #(
  parameter int ROWS     = 8,
  parameter int SB       = 32,
  parameter int VBASE    = 16,
  parameter int TBL_PAGE = 1,
  parameter int H_ACT    = 16,
  parameter int H_FP     = 2,
  parameter int H_SYNC   = 3,
  parameter int H_BP     = 3,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] haddr_i,
  input  logic [7:0]  hdata_i,
  input  logic        hwe_i,
  output logic [7:0]  pix_o,
  output logic        de_o,
  output logic        hs_o,
  output logic        vs_o,
  output logic [7:0]  mode_o
);
  localparam int V_ACT = 4 * ROWS;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(SB);
  localparam int HS0   = H_ACT + H_FP;
  localparam int HS1   = HS0 + H_SYNC;
  localparam int VS0   = V_ACT + V_FP;
  localparam int VS1   = VS0 + V_SYNC;

  logic [7:0]    fb [ROWS*SB];
  logic [7:0]    tpg [ROWS];
  logic [7:0]    tof [ROWS];
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0]    rdata;
  logic          ok_q;

  wire [7:0] wpg   = haddr_i[15:8];
  wire [7:0] woff  = haddr_i[7:0];
  wire [7:0] wrow  = wpg - 8'(VBASE);
  wire       fb_hit  = hwe_i && (wrow < 8'(ROWS)) && (woff < 8'(SB));
  wire       tbl_hit = hwe_i && (wpg == 8'(TBL_PAGE)) && (woff < 8'(2*ROWS));
  wire [RW+CW-1:0] waddr = {wrow[RW-1:0], woff[CW-1:0]};

  wire           h_last = (hcnt == HW'(H_TOT-1));
  wire           act    = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
  wire [RW-1:0]  row    = vcnt[RW+1:2];
  wire [7:0]     rp     = tpg[row] - 8'(VBASE);
  wire [7:0]     col    = tof[row] + 8'(hcnt);
  wire           src_ok = act && (rp < 8'(ROWS)) && (mode_o == 8'd0);
  wire [RW+CW-1:0] raddr = {rp[RW-1:0], col[CW-1:0]};
  wire [7:0]     pend   = (tpg[0] == 8'd0) ? tof[0] : 8'd0;

  always_ff @(posedge clk) begin
    rdata <= fb[raddr];
    if (fb_hit) fb[waddr] <= hdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        tpg[i] <= 8'd0;
        tof[i] <= 8'd0;
      end
    end else if (tbl_hit) begin
      if (woff[0]) tof[woff[RW:1]] <= hdata_i;
      else         tpg[woff[RW:1]] <= hdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      vcnt   <= '0;
      mode_o <= 8'd0;
      ok_q   <= 1'b0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
    end else begin
      hcnt <= h_last ? '0 : hcnt + 1'b1;
      if (h_last) vcnt <= (vcnt == VW'(V_TOT-1)) ? '0 : vcnt + 1'b1;
      if (h_last && vcnt == VW'(V_ACT-1)) mode_o <= pend;
      ok_q <= src_ok;
      de_o <= act;
      hs_o <= (hcnt >= HW'(HS0)) && (hcnt < HW'(HS1));
      vs_o <= (vcnt >= VW'(VS0)) && (vcnt < VW'(VS1));
    end
  end

  assign pix_o = ok_q ? rdata : 8'd0;
endmodule

// File: rtl/shadow_vidctl_chk.sv
module shadow_vidctl_chk #(
  parameter int H_TOT = 24,
  parameter int V_TOT = 36,
  parameter int V_ACT = 32,
  parameter int HW    = 5,
  parameter int VW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    pix_o,
  input logic          de_o,
  input logic          hs_o,
  input logic          vs_o,
  input logic [7:0]    mode_o,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt
);
  // R4
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hs_o && !vs_o));
  // R10
  pix_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_o != 8'd0) |-> (de_o && mode_o == 8'd0));
  // R9
  mode_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> (vcnt == VW'(V_ACT) && hcnt == '0));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < HW'(H_TOT)) && (vcnt < VW'(V_TOT)));
  // R12
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (!de_o && !hs_o && !vs_o && pix_o == 8'd0 && mode_o == 8'd0));
endmodule

bind shadow_vidctl shadow_vidctl_chk #(
  .H_TOT(H_TOT), .V_TOT(V_TOT), .V_ACT(V_ACT), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_o(pix_o), .de_o(de_o), .hs_o(hs_o),
  .vs_o(vs_o), .mode_o(mode_o), .hcnt(hcnt), .vcnt(vcnt)
);

// File: tb/sim_shadow_vidctl.sv
module sim_shadow_vidctl;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8, SB = 32, VBASE = 16, TBL = 1;
  localparam int H_ACT = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int V_ACT = 4 * ROWS;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;

  logic clk = 0, rst_n = 0, hwe = 0;
  logic [15:0] haddr = 0;
  logic [7:0]  hdata = 0;
  logic [7:0]  pix, mode;
  logic        de, hs, vs;

  shadow_vidctl u0 (.clk(clk), .rst_n(rst_n), .haddr_i(haddr), .hdata_i(hdata),
    .hwe_i(hwe), .pix_o(pix), .de_o(de), .hs_o(hs), .vs_o(vs), .mode_o(mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;
  string phase = "R12 reset";

  int sh [int];
  int tp [ROWS], tf [ROWS];
  int mh = 0, mv = 0, mmode = 0;
  int e_pix = 0, e_mode = 0;
  bit e_de = 0, e_hs = 0, e_vs = 0;

  always @(posedge clk) begin
    int pg, off, rp;
    if (!rst_n) begin
      mh = 0; mv = 0; mmode = 0;
      foreach (tp[i]) begin tp[i] = 0; tf[i] = 0; end
      e_pix = 0; e_de = 0; e_hs = 0; e_vs = 0; e_mode = 0;
    end else begin
      e_de = (mh < H_ACT) && (mv < V_ACT);
      e_hs = (mh >= H_ACT + H_FP) && (mh < H_ACT + H_FP + H_SYNC);
      e_vs = (mv >= V_ACT + V_FP) && (mv < V_ACT + V_FP + V_SYNC);
      e_pix = 0;
      if (e_de && mmode == 0) begin
        rp = tp[mv / 4] - VBASE;
        if (rp >= 0 && rp < ROWS) begin
          int k;
          k = rp * SB + ((tf[mv / 4] + mh) % SB);
          e_pix = sh.exists(k) ? sh[k] : 0;
        end
      end
      if (mh == H_TOT - 1 && mv == V_ACT - 1) mmode = (tp[0] == 0) ? tf[0] : 0;
      e_mode = mmode;
      if (hwe) begin
        pg = int'(haddr[15:8]); off = int'(haddr[7:0]);
        if (pg >= VBASE && pg < VBASE + ROWS && off < SB) sh[(pg - VBASE) * SB + off] = int'(hdata);
        if (pg == TBL && off < 2 * ROWS) begin
          if (off % 2 == 1) tf[off / 2] = int'(hdata); else tp[off / 2] = int'(hdata);
        end
      end
      mh = mh + 1;
      if (mh == H_TOT) begin
        mh = 0;
        mv = (mv == V_TOT - 1) ? 0 : mv + 1;
      end
    end
  end

  task automatic cmp(string rq, string sig, int got, int exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s [%s] t=%0t got %0d expected %0d", rq, sig, phase, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && cycles > 1) begin
      vectors++;
      cmp("R6", "pix_o", int'(pix), e_pix);
      cmp("R4", "de_o", int'(de), int'(e_de));
      cmp("R3", "hs_o", int'(hs), int'(e_hs));
      cmp("R3", "vs_o", int'(vs), int'(e_vs));
      cmp("R9", "mode_o", int'(mode), e_mode);
    end
    cycles++;
  end

  task automatic wr(int pg, int off, int d);
    @(negedge clk);
    haddr = 16'((pg << 8) | off); hdata = 8'(d); hwe = 1;
  endtask

  task automatic idle(int n);
    @(negedge clk); hwe = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_line(int v);
    while (!(mv == v && mh == 3)) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h1234_5679;
    repeat (4) @(negedge clk);
    // R12: outputs held at zero in reset
    phase = "R12 reset";
    if (pix != 0 || de || hs || vs || mode != 0) begin
      errors++;
      $display("FAIL R12 reset outputs got %0d/%0d/%0d/%0d/%0d expected all 0", pix, de, hs, vs, mode);
    end
    vectors++;
    rst_n = 1;
    // R1 / R7: fill shadow memory while the zeroed table points at page 0
    phase = "R1 R7 fill";
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < SB; c++) wr(VBASE + r, c, (r * 37 + c * 5 + 1) & 255);
    idle(2);
    // R6: indirection with permuted pages and varied offsets (wrap at SB)
    phase = "R6 indirection";
    for (int r = 0; r < ROWS; r++) begin
      wr(TBL, 2 * r, VBASE + ((r * 3 + 1) % ROWS));
      wr(TBL, 2 * r + 1, r * 5);
    end
    idle(1);
    // R5: line quadding over two full frames
    phase = "R5 quadding";
    idle(2 * H_TOT * V_TOT);
    // R7: out-of-range page and page 0 outside entry 0
    phase = "R7 bad page";
    wr(TBL, 4, 8'h40); wr(TBL, 6, 0); wr(TBL, 8, VBASE - 1);
    idle(H_TOT * V_TOT);
    // R2: ignored writes of every kind
    phase = "R2 ignored";
    for (int i = 0; i < 64; i++) begin
      wr(VBASE + ROWS, i % SB, 8'hEE);
      wr(VBASE + (i % ROWS), SB + i, 8'hDD);
      wr(TBL, 2 * ROWS + i, 0);
      wr(VBASE - 1, i, 8'hCC);
      @(negedge clk); haddr = 16'(((VBASE + i % ROWS) << 8) | (i % SB)); hdata = 8'hAA; hwe = 0;
    end
    idle(H_TOT * V_TOT);
    // R11: dense writes during active display, including same-cycle read/write
    phase = "R11 live writes";
    for (int i = 0; i < H_TOT * V_TOT; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      wr(VBASE + ((seed >>> 8) & (ROWS - 1)), seed & (SB - 1), (seed >>> 16) & 255);
    end
    idle(H_TOT * V_TOT);
    // R8 / R9 / R10: magic entry written mid-frame, switch at vblank
    phase = "R8 R9 R10 mode";
    wait_line(10);
    wr(TBL, 1, 5); wr(TBL, 0, 0);
    idle(2 * H_TOT * V_TOT);
    wait_line(20);
    phase = "R9 back to 0";
    wr(TBL, 0, VBASE + 2);
    idle(2 * H_TOT * V_TOT);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule